// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects 64 interrupt inputs and presents them to a processor on two request lines: a fast line for the most urgent sources and a normal line for the rest. Each input is edge-detected into a pending bit. Each source also has an enable bit and a 3-bit priority. The priority decides which line the source uses, and it ranks the source against the other sources on that line. For each line the controller also drives an entry address. The address is a programmable base plus four times the number of the winning source, so a handler can branch straight to the right slot.

Software reaches the block through a plain 32-bit register port. A write is a single strobe with an address and data and takes effect at the next clock edge. The read data is combinational from the address. There is no streaming data path, so the port has no valid/ready handshake and no back-pressure.

Top module: `prio_intc`

## Requirements
- R1: After reset every pending and enable bit is 0, every priority is 7, the base and control registers read 0, and both request lines are low with entry outputs at 0.
- R2: A 0-to-1 change on `src_i[n]` sets pending bit n at the same edge, whether or not the source is enabled. A pending bit becomes set only through such a change. If a set and a clear hit the same source in one cycle, the bit ends up set.
- R3: The fast-line pending words sit at byte offsets 0x00 (sources 0–31) and 0x04 (sources 32–63), and the normal-line words at 0x08 and 0x0C. Bit n mod 32 stands for source n. A read returns the pending bits of the sources currently steered to that line. Writing 1 to a bit clears it only if the source is steered to that line, and writing 0 leaves the bit as it was.
- R4: The enable words sit at 0x18 (sources 0–31) and 0x1C (sources 32–63), using the same bit mapping. A source takes part in arbitration only while its enable bit is 1. Clearing the enable bit removes the source's request at the next edge.
- R5: The priority registers sit at 0x30 + 4·(n/8). Source n uses bits [4k+2:4k] with k = n mod 8. Bit 4k+3 is ignored on write and reads as 0.
- R6: A source with priority 0 or 1 is steered to the fast line (`fiq_req`). A source with priority 2 to 7 is steered to the normal line (`irq_req`).
- R7: Each request line is registered. It is high in the cycle after an edge at which at least one pending, enabled source steered to that line exists.
- R8: On each line the winner is the pending, enabled source with the smallest priority value. Among equal priorities, the lowest source number wins.
- R9: Each entry output is registered together with its request line. It equals base + 4·winner, and it equals the base when no source is requesting on that line.
- R10: The base register at 0x24 and the control register at 0x20 hold full 32-bit values that read back as written. Control value 0 selects immediate masking, which is the only behaviour implemented.
- R11: Any address not listed above reads as 0, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Interrupt source inputs, rising edge sets pending |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| fiq_req | output | 1 | Fast-line request |
| irq_req | output | 1 | Normal-line request |
| fiq_entry | output | 32 | Fast-line entry address |
| irq_entry | output | 32 | Normal-line entry address |

## Verification
Directed patterns come first. Two fast-line sources are raised with priorities 0 and 1, which checks that the smaller value wins. Two normal-line sources are raised with equal priority, which checks that the lower number breaks the tie. A source is raised while disabled and then enabled, which separates pending from requesting. A clear is written to the wrong line's word, which must leave the bit set. A clear is written in the same cycle as a new rising edge on that source, which must leave the bit set. After that, a long random mix of input toggles and register writes runs against a behavioural model. The random phase exercises priority changes that move already-pending sources from one line to the other.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_W        = 32;
  localparam int SRC_PER_WORD = 32;
  localparam int PRI_PER_REG  = 8;
  localparam int NIB_W        = 4;
  // word indices (byte offset / 4)
  localparam int W_FIQ0  = 0;
  localparam int W_IRQ0  = 2;
  localparam int W_EN0   = 6;
  localparam int W_CTRL  = 8;
  localparam int W_BASE  = 9;
  localparam int W_PRI0  = 12;
  localparam int FAST_PRI_LIMIT = 2;
endpackage

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] src_q;

  assign rise_o = src_i & ~src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_o <= '0;
    end else begin
      src_q  <= src_i;
      pend_o <= (pend_o & ~clr_i) | rise_o;
    end
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N      = 64,
  parameter int PW     = 3,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wen_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  input  logic [N-1:0]          pend_i,
  input  logic [N-1:0]          fast_i,
  output logic [REG_W-1:0]      rdata_o,
  output logic [N-1:0]          en_o,
  output logic [N-1:0][PW-1:0]  pri_o,
  output logic [REG_W-1:0]      base_o,
  output logic [N-1:0]          clr_o
);
  localparam int NW     = N / SRC_PER_WORD;
  localparam int NP     = N / PRI_PER_REG;
  localparam int WSEL_W = ADDR_W - 2;

  logic [WSEL_W-1:0] wsel;
  logic [REG_W-1:0]  ctrl_q;

  assign wsel = addr_i[ADDR_W-1:2];

  always_comb begin
    clr_o = '0;
    if (wen_i) begin
      for (int w = 0; w < NW; w++) begin
        if (wsel == WSEL_W'(W_FIQ0 + w))
          clr_o[w*SRC_PER_WORD +: SRC_PER_WORD] = wdata_i & fast_i[w*SRC_PER_WORD +: SRC_PER_WORD];
        if (wsel == WSEL_W'(W_IRQ0 + w))
          clr_o[w*SRC_PER_WORD +: SRC_PER_WORD] = wdata_i & ~fast_i[w*SRC_PER_WORD +: SRC_PER_WORD];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o   <= '0;
      pri_o  <= '1;
      base_o <= '0;
      ctrl_q <= '0;
    end else if (wen_i) begin
      for (int w = 0; w < NW; w++)
        if (wsel == WSEL_W'(W_EN0 + w))
          en_o[w*SRC_PER_WORD +: SRC_PER_WORD] <= wdata_i;
      if (wsel == WSEL_W'(W_CTRL)) ctrl_q <= wdata_i;
      if (wsel == WSEL_W'(W_BASE)) base_o <= wdata_i;
      for (int r = 0; r < NP; r++)
        if (wsel == WSEL_W'(W_PRI0 + r))
          for (int k = 0; k < PRI_PER_REG; k++)
            pri_o[r*PRI_PER_REG + k] <= wdata_i[k*NIB_W +: PW];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NW; w++) begin
      if (wsel == WSEL_W'(W_FIQ0 + w))
        rdata_o = pend_i[w*SRC_PER_WORD +: SRC_PER_WORD] & fast_i[w*SRC_PER_WORD +: SRC_PER_WORD];
      if (wsel == WSEL_W'(W_IRQ0 + w))
        rdata_o = pend_i[w*SRC_PER_WORD +: SRC_PER_WORD] & ~fast_i[w*SRC_PER_WORD +: SRC_PER_WORD];
      if (wsel == WSEL_W'(W_EN0 + w))
        rdata_o = en_o[w*SRC_PER_WORD +: SRC_PER_WORD];
    end
    if (wsel == WSEL_W'(W_CTRL)) rdata_o = ctrl_q;
    if (wsel == WSEL_W'(W_BASE)) rdata_o = base_o;
    for (int r = 0; r < NP; r++)
      if (wsel == WSEL_W'(W_PRI0 + r))
        for (int k = 0; k < PRI_PER_REG; k++)
          rdata_o[k*NIB_W +: PW] = pri_o[r*PRI_PER_REG + k];
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int N  = 64,
  parameter int PW = 3,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]          req_i,
  input  logic [N-1:0][PW-1:0]  pri_i,
  output logic                  found_o,
  output logic [IW-1:0]         idx_o
);
  logic [PW-1:0] best;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = 0; i < N; i++) begin
      // strict compare on an ascending scan keeps the lower index on ties
      if (req_i[i] && (!found_o || (pri_i[i] < best))) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        best    = pri_i[i];
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N      = 64,
  parameter int PW     = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_i,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              fiq_req,
  output logic              irq_req,
  output logic [REG_W-1:0]  fiq_entry,
  output logic [REG_W-1:0]  irq_entry
);
  localparam int IW = $clog2(N);

  logic [N-1:0]         pend_w, rise_w, clr_w, en_w, fast_w;
  logic [N-1:0][PW-1:0] pri_w;
  logic [REG_W-1:0]     base_w;
  logic [N-1:0]         fast_cand, norm_cand;
  logic                 fast_found, norm_found;
  logic [IW-1:0]        fast_idx, norm_idx;

  intc_pend #(.N(N)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .clr_i(clr_w),
    .pend_o(pend_w), .rise_o(rise_w)
  );

  intc_regs #(.N(N), .PW(PW), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen_i(bus_wen), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .pend_i(pend_w), .fast_i(fast_w),
    .rdata_o(bus_rdata), .en_o(en_w), .pri_o(pri_w), .base_o(base_w),
    .clr_o(clr_w)
  );

  for (genvar g = 0; g < N; g++) begin : g_route
    assign fast_w[g] = (pri_w[g] < PW'(FAST_PRI_LIMIT));
  end

  assign fast_cand = pend_w & en_w & fast_w;
  assign norm_cand = pend_w & en_w & ~fast_w;

  intc_arb #(.N(N), .PW(PW)) u_arb_fast (
    .req_i(fast_cand), .pri_i(pri_w), .found_o(fast_found), .idx_o(fast_idx)
  );

  intc_arb #(.N(N), .PW(PW)) u_arb_norm (
    .req_i(norm_cand), .pri_i(pri_w), .found_o(norm_found), .idx_o(norm_idx)
  );

  // idx is 0 when nothing is found, so the entry falls back to the base
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_req   <= 1'b0;
      irq_req   <= 1'b0;
      fiq_entry <= '0;
      irq_entry <= '0;
    end else begin
      fiq_req   <= fast_found;
      irq_req   <= norm_found;
      fiq_entry <= base_w + (REG_W'(fast_idx) << 2);
      irq_entry <= base_w + (REG_W'(norm_idx) << 2);
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int N = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] rise,
  input logic [N-1:0] pend,
  input logic [N-1:0] en,
  input logic [N-1:0] fast,
  input logic [31:0]  base,
  input logic         fiq_req,
  input logic         irq_req,
  input logic [31:0]  fiq_entry,
  input logic [31:0]  irq_entry
);
  AST_RISE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend & $past(rise)) == $past(rise))); // R2
  AST_PEND_ONLY_BY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend & ~$past(pend) & ~$past(rise)) == '0)); // R2
  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && (en == '0)) |=> (!fiq_req && !irq_req)); // R4
  AST_FIQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && fiq_req) |-> $past(|(pend & en & fast))); // R6
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && irq_req) |-> $past(|(pend & en & ~fast))); // R6
  AST_FIQ_IDLE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !fiq_req) |-> (fiq_entry == $past(base))); // R9
  AST_IRQ_IDLE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !irq_req) |-> (irq_entry == $past(base))); // R9
endmodule

bind prio_intc prio_intc_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise_w), .pend(pend_w), .en(en_w),
  .fast(fast_w), .base(base_w), .fiq_req(fiq_req), .irq_req(irq_req),
  .fiq_entry(fiq_entry), .irq_entry(irq_entry)
);

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        bus_wen = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, fiq_entry, irq_entry;
  logic        fiq_req, irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  prio_intc uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fiq_req(fiq_req), .irq_req(irq_req), .fiq_entry(fiq_entry),
    .irq_entry(irq_entry)
  );

  // behavioural reference state
  bit [63:0]   m_pend = '0, m_en = '0, m_prev = '0;
  int          m_pri [64];
  logic [31:0] m_base = '0, m_ctrl = '0;
  logic        x_fiq = 1'b0, x_irq = 1'b0;
  logic [31:0] x_fent = '0, x_ient = '0;

  initial for (int i = 0; i < 64; i++) m_pri[i] = 7;

  function automatic logic [31:0] mread(logic [7:0] a);
    int s;
    logic [31:0] v;
    s = int'(a[7:2]);
    v = '0;
    if (s <= 1) begin
      for (int b = 0; b < 32; b++) v[b] = m_pend[s*32+b] && (m_pri[s*32+b] < 2);
    end else if (s <= 3) begin
      for (int b = 0; b < 32; b++) v[b] = m_pend[(s-2)*32+b] && (m_pri[(s-2)*32+b] >= 2);
    end else if (s == 6 || s == 7) begin
      for (int b = 0; b < 32; b++) v[b] = m_en[(s-6)*32+b];
    end else if (s == 8) v = m_ctrl;
    else if (s == 9) v = m_base;
    else if (s >= 12 && s <= 19) begin
      for (int k = 0; k < 8; k++) v[4*k +: 3] = 3'(m_pri[(s-12)*8+k]);
    end
    return v;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    int s;
    s = int'(a[7:2]);
    if (s <= 3) return "R3";
    if (s == 6 || s == 7) return "R4";
    if (s == 8 || s == 9) return "R10";
    if (s >= 12 && s <= 19) return "R5";
    return "R11";
  endfunction

  always @(posedge clk) begin
    int wf, bf, wi, bi, s, n;
    bit [63:0] clr;
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_prev = '0; m_base = '0; m_ctrl = '0;
      for (int i = 0; i < 64; i++) m_pri[i] = 7;
      x_fiq = 0; x_irq = 0; x_fent = '0; x_ient = '0;
    end else begin
      wf = -1; bf = 8; wi = -1; bi = 8;
      for (int i = 0; i < 64; i++)
        if (m_pend[i] && m_en[i]) begin
          if (m_pri[i] < 2) begin
            if (m_pri[i] < bf) begin bf = m_pri[i]; wf = i; end
          end else if (m_pri[i] < bi) begin bi = m_pri[i]; wi = i; end
        end
      x_fiq  = (wf >= 0);
      x_irq  = (wi >= 0);
      x_fent = m_base + ((wf >= 0) ? 32'(4*wf) : 32'd0);
      x_ient = m_base + ((wi >= 0) ? 32'(4*wi) : 32'd0);
      clr = '0;
      s = int'(bus_addr[7:2]);
      if (bus_wen && s <= 3)
        for (int b = 0; b < 32; b++)
          if (bus_wdata[b]) begin
            n = (s % 2) * 32 + b;
            if ((s <= 1) == (m_pri[n] < 2)) clr[n] = 1;
          end
      for (int i = 0; i < 64; i++) begin
        if (clr[i]) m_pend[i] = 0;
        if (src[i] && !m_prev[i]) m_pend[i] = 1;
        m_prev[i] = src[i];
      end
      if (bus_wen) begin
        if (s == 6) m_en[31:0] = bus_wdata;
        if (s == 7) m_en[63:32] = bus_wdata;
        if (s == 8) m_ctrl = bus_wdata;
        if (s == 9) m_base = bus_wdata;
        if (s >= 12 && s <= 19)
          for (int k = 0; k < 8; k++) m_pri[(s-12)*8+k] = int'(bus_wdata[4*k +: 3]);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 fiq_req", 32'(fiq_req), 32'(x_fiq));
      chk("R7 irq_req", 32'(irq_req), 32'(x_irq));
      chk("R9 fiq_entry", fiq_entry, x_fent);
      chk("R9 irq_entry", irq_entry, x_ient);
      chk(tag_of(bus_addr), bus_rdata, mread(bus_addr));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2;
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wen = 1'b0;
  endtask

  task automatic setsrc(int n, logic v);
    @(posedge clk); #2;
    src[n] = v;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    @(posedge clk); #2;
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    int s;
    logic [7:0] amap [18];
    amap = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h30,
             8'h34, 8'h38, 8'h3C, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h10, 8'h28};
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 fiq_req", 32'(fiq_req), 32'd0);
    chk("R1 irq_entry", irq_entry, 32'd0);
    rd_chk("R1 priority reset", 8'h48, 32'h7777_7777);
    rd_chk("R1 enable reset", 8'h1C, 32'h0);
    rd_chk("R1 base reset", 8'h24, 32'h0);

    wr(8'h30, 32'hFFFF_FFFF);
    rd_chk("R5 nibble top bit ignored", 8'h30, 32'h7777_7777);
    wr(8'h30, 32'h7654_3210);
    rd_chk("R5 packing", 8'h30, 32'h7654_3210);

    setsrc(2, 1'b1);
    settle();
    rd_chk("R2 pending while disabled", 8'h08, 32'h4);
    chk("R4 no request while disabled", 32'(irq_req), 32'd0);

    wr(8'h18, 32'hFFFF_FFFF);
    settle();
    chk("R6 normal line for pri 2", 32'(irq_req), 32'd1);
    chk("R9 entry base 0", irq_entry, 32'h8);

    wr(8'h24, 32'h1000);
    settle();
    rd_chk("R10 base readback", 8'h24, 32'h1000);
    chk("R9 entry with base", irq_entry, 32'h1008);
    wr(8'h20, 32'hA5A5_0000);
    rd_chk("R10 control readback", 8'h20, 32'hA5A5_0000);
    wr(8'h20, 32'h0);

    setsrc(1, 1'b1);
    settle();
    chk("R6 fast line for pri 1", 32'(fiq_req), 32'd1);
    chk("R8 single fast winner", fiq_entry, 32'h1004);
    setsrc(0, 1'b1);
    settle();
    chk("R8 pri 0 beats pri 1", fiq_entry, 32'h1000);

    wr(8'h44, 32'h3333_3333);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h08, 32'h4);
    setsrc(45, 1'b1);
    setsrc(41, 1'b1);
    settle();
    rd_chk("R3 clear on normal word", 8'h08, 32'h0);
    chk("R8 tie lowest number", irq_entry, 32'h1000 + 32'd164);

    wr(8'h08, 32'h1);
    rd_chk("R3 wrong line clear ignored", 8'h00, 32'h3);
    wr(8'h00, 32'h2);
    rd_chk("R3 fast clear", 8'h00, 32'h1);

    @(posedge clk); #2;
    src[3] = 1'b1; bus_wen = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h8;
    @(posedge clk); #2;
    bus_wen = 1'b0;
    rd_chk("R2 set beats clear", 8'h08, 32'h8);
    settle();
    chk("R8 tie 3 vs 41", irq_entry, 32'h100C);

    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk("R3 clear all word 1", 8'h0C, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);
    rd_chk("R11 unmapped reads zero", 8'h28, 32'h0);

    wr(8'h18, 32'h0);
    wr(8'h1C, 32'h0);
    @(negedge clk);
    chk("R4 disable drops request", 32'(irq_req), 32'd0);
    chk("R4 disable drops fast", 32'(fiq_req), 32'd0);
    chk("R9 idle entry is base", irq_entry, 32'h1000);

    for (int c = 0; c < 4000; c++) begin
      @(posedge clk); #2;
      src[$urandom_range(0, 63)] = 1'($urandom);
      s = $urandom_range(0, 17);
      bus_addr = amap[s];
      bus_wen = ($urandom_range(0, 3) == 0);
      bus_wdata = $urandom;
    end
    @(posedge clk); #2;
    bus_wen = 1'b0;
    settle();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule